// File: doc/BRIEF.md
# Serial host to parallel display bus bridge with read-back

The bridge sits between a host SPI master (mode 0, MSB first) and a display controller that has a 16-bit parallel bus. Each chip-select window carries one frame. The level of the host's data/command line, sampled when chip select goes low, sets the frame length: 8 bits for a command, 16 bits for data. When a frame completes, the bridge starts a write cycle on the parallel bus. It drives the word and the controller's data/command line, then holds the write strobe low for a set number of clocks and releases it. The controller captures the word on that rising edge.

The bridge decodes every command byte against a small table of opcodes that return data. After a read-type command, the data frames that follow no longer cause writes. Each of them instead ends in a read cycle: the bridge releases the bus, pulses the read strobe and captures the word the controller drives. That word goes back to the host on MISO during the next transfer. The first data transfer after the command therefore returns nothing. A final drain transfer collects the last word and causes no bus activity. All serial inputs are oversampled by the system clock.

Top module: `spi_disp_bridge`

## Requirements
- R1: After reset, wrx and rdx are 1, bus_oe is 1, bus_out is 0 and miso is 0.
- R2: The dc level sampled when cs_n falls sets the frame length: 0 gives an 8-bit command frame, 1 gives a 16-bit data frame. Bits are taken MSB first on rising sclk edges. Clocks beyond the frame length within the same chip-select window are ignored.
- R3: If cs_n rises before the frame length is reached, the bits received so far are used, right-justified and zero-extended. A window with no sclk edges causes no bus cycle.
- R4: A command frame produces a write cycle: bus_out = {8'h00, command byte}, disp_dc = 0, bus_oe = 1, and wrx is low for STROBE_CYC clocks before rising.
- R5: A data frame outside a read phase produces a write cycle with the full 16-bit word and disp_dc = 1.
- R6: Read-type opcodes and their word counts are 0x04→3, 0x09→3, 0x0A→1 and 0x0C→1. Every other opcode starts no read phase.
- R7: After a read-type command with count N, each of the next N data frames ends in a read cycle instead of a write. In that cycle bus_oe is 0 and rdx is low for STROBE_CYC clocks, and bus_in is captured when rdx rises.
- R8: The data frame that follows the N read frames is a drain frame with no write and no read cycle. Later data frames are written normally.
- R9: A word captured by a read cycle is shifted out on miso, MSB first, during the next transfer, changing after each falling sclk edge. miso is 0 in any transfer that has no captured word, including the dummy first data transfer after a read command.
- R10: A command frame that arrives during a read phase ends that phase. The following data frames are writes.
- R11: bus_oe stays 0 from a read cycle until the next write cycle. wrx and rdx are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; one frame per assertion |
| mosi | input | 1 | Serial data from the host |
| dc | input | 1 | Host data/command select, sampled when cs_n falls |
| miso | output | 1 | Serial read-back data to the host |
| bus_in | input | 16 | Parallel bus value driven by the controller |
| bus_out | output | 16 | Parallel bus value driven by the bridge |
| bus_oe | output | 1 | High while the bridge drives the parallel bus |
| disp_dc | output | 1 | Data/command select to the controller |
| wrx | output | 1 | Active-low write strobe; rising edge captures |
| rdx | output | 1 | Active-low read strobe |

## Verification
The bench sends commands and data through frames of full length, short frames, overlong frames and empty windows. This shows whether framing follows the sampled dc level and the chip-select edges. Read commands with one-word and three-word counts are followed by data frames carrying don't-care MOSI content. For each one the bench checks that only reads, and no writes, reach the bus, that each returned word comes back exactly one transfer late, and that the drain frame is silent. Opcodes not in the table, and a command that cuts a read phase short, show that writes resume at once.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
    localparam int unsigned WORD_W = 16;
    localparam int unsigned CMD_W  = 8;
    localparam int unsigned CNT_W  = $clog2(WORD_W + 1);
    localparam int unsigned RDN_W  = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } bus_op_e;

    typedef struct packed {
        logic              done;
        logic              is_data;
        logic [WORD_W-1:0] word;
    } frame_t;

    typedef struct packed {
        bus_op_e           op;
        logic              is_data;
        logic [WORD_W-1:0] word;
    } bus_req_t;

    function automatic logic [RDN_W-1:0] read_words(input logic [CMD_W-1:0] opc);
        case (opc)
            8'h04:   return RDN_W'(3);
            8'h09:   return RDN_W'(3);
            8'h0A:   return RDN_W'(1);
            8'h0C:   return RDN_W'(1);
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/sdb_frame_rx.sv
module sdb_frame_rx
    import sdb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sclk,
    input  logic   cs_n,
    input  logic   mosi,
    input  logic   dc,
    output frame_t frame,
    output logic   cs_fall,
    output logic   cs_rise,
    output logic   sclk_fall
);
    logic s_sclk, s_cs, s_mosi, s_dc, p_sclk, p_cs;
    logic sclk_rise;
    logic active, len16;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  target;
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] sh_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_sclk <= 1'b0;
            s_cs   <= 1'b1;
            s_mosi <= 1'b0;
            s_dc   <= 1'b0;
            p_sclk <= 1'b0;
            p_cs   <= 1'b1;
        end else begin
            s_sclk <= sclk;
            s_cs   <= cs_n;
            s_mosi <= mosi;
            s_dc   <= dc;
            p_sclk <= s_sclk;
            p_cs   <= s_cs;
        end
    end

    assign cs_fall   = p_cs & ~s_cs;
    assign cs_rise   = ~p_cs & s_cs;
    assign sclk_rise = ~p_sclk & s_sclk & ~s_cs;
    assign sclk_fall = p_sclk & ~s_sclk & ~s_cs;
    assign target    = len16 ? CNT_W'(WORD_W) : CNT_W'(CMD_W);
    assign sh_next   = {sh[WORD_W-2:0], s_mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            len16   <= 1'b0;
            cnt     <= '0;
            sh      <= '0;
            frame   <= '0;
        end else begin
            frame.done <= 1'b0;
            if (cs_fall) begin
                active <= 1'b1;
                len16  <= s_dc;
                cnt    <= '0;
                sh     <= '0;
            end else if (active && sclk_rise) begin
                sh  <= sh_next;
                cnt <= cnt + 1'b1;
                if (cnt + 1'b1 == target) begin
                    active        <= 1'b0;
                    frame.done    <= 1'b1;
                    frame.is_data <= len16;
                    frame.word    <= sh_next;
                end
            end else if (active && cs_rise) begin
                active <= 1'b0;
                if (cnt != '0) begin
                    frame.done    <= 1'b1;
                    frame.is_data <= len16;
                    frame.word    <= sh;
                end
            end
        end
    end
endmodule

// File: rtl/sdb_cmd_tracker.sv
module sdb_cmd_tracker
    import sdb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  frame_t   frame,
    output bus_req_t req
);
    logic [RDN_W-1:0] rd_left;
    logic             drain;
    logic [RDN_W-1:0] n_words;

    assign n_words = read_words(frame.word[CMD_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_left <= '0;
            drain   <= 1'b0;
            req     <= '{op: OP_NONE, is_data: 1'b0, word: '0};
        end else begin
            req.op <= OP_NONE;
            if (frame.done) begin
                if (!frame.is_data) begin
                    req.op      <= OP_WRITE;
                    req.is_data <= 1'b0;
                    req.word    <= {{(WORD_W-CMD_W){1'b0}}, frame.word[CMD_W-1:0]};
                    rd_left     <= n_words;
                    drain       <= (n_words != '0);
                end else if (rd_left != '0) begin
                    req.op  <= OP_READ;
                    rd_left <= rd_left - 1'b1;
                end else if (drain) begin
                    drain <= 1'b0;
                end else begin
                    req.op      <= OP_WRITE;
                    req.is_data <= 1'b1;
                    req.word    <= frame.word;
                end
            end
        end
    end
endmodule

// File: rtl/sdb_bus_seq.sv
module sdb_bus_seq
    import sdb_pkg::*;
#(
    parameter int unsigned STROBE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [WORD_W-1:0] bus_in,
    output logic [WORD_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              disp_dc,
    output logic              wrx,
    output logic              rdx,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_word
);
    localparam int unsigned SW = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
    localparam logic [SW-1:0] LOAD = SW'(STROBE_CYC - 1);

    logic [SW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_out  <= '0;
            bus_oe   <= 1'b1;
            disp_dc  <= 1'b0;
            wrx      <= 1'b1;
            rdx      <= 1'b1;
            cnt      <= '0;
            rd_valid <= 1'b0;
            rd_word  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (!wrx || !rdx) begin
                if (cnt == '0) begin
                    if (!wrx) begin
                        wrx <= 1'b1;
                    end else begin
                        rdx      <= 1'b1;
                        rd_word  <= bus_in;
                        rd_valid <= 1'b1;
                    end
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end else if (req.op == OP_WRITE) begin
                bus_out <= req.word;
                disp_dc <= req.is_data;
                bus_oe  <= 1'b1;
                wrx     <= 1'b0;
                cnt     <= LOAD;
            end else if (req.op == OP_READ) begin
                bus_oe <= 1'b0;
                rdx    <= 1'b0;
                cnt    <= LOAD;
            end
        end
    end
endmodule

// File: rtl/sdb_miso_tx.sv
module sdb_miso_tx
    import sdb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sclk_fall,
    input  logic [WORD_W-1:0] load_word,
    output logic              miso
);
    logic [WORD_W-1:0] tx;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx <= '0;
        end else if (cs_fall) begin
            tx <= load_word;
        end else if (cs_rise) begin
            tx <= '0;
        end else if (sclk_fall) begin
            tx <= {tx[WORD_W-2:0], 1'b0};
        end
    end

    assign miso = tx[WORD_W-1];
endmodule

// File: rtl/spi_disp_bridge.sv
module spi_disp_bridge
    import sdb_pkg::*;
#(
    parameter int unsigned STROBE_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic              dc,
    output logic              miso,
    input  logic [WORD_W-1:0] bus_in,
    output logic [WORD_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              disp_dc,
    output logic              wrx,
    output logic              rdx
);
    frame_t            frame;
    bus_req_t          req;
    logic              cs_fall, cs_rise, sclk_fall;
    logic              rd_valid;
    logic [WORD_W-1:0] rd_word;
    logic              pend;
    logic [WORD_W-1:0] pend_word;
    logic [WORD_W-1:0] load_word;

    sdb_frame_rx u_rx (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .dc(dc),
        .frame(frame), .cs_fall(cs_fall), .cs_rise(cs_rise), .sclk_fall(sclk_fall)
    );

    sdb_cmd_tracker u_trk (
        .clk(clk), .rst(rst), .frame(frame), .req(req)
    );

    sdb_bus_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk(clk), .rst(rst), .req(req), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .disp_dc(disp_dc),
        .wrx(wrx), .rdx(rdx), .rd_valid(rd_valid), .rd_word(rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_word <= '0;
        end else if (rd_valid) begin
            pend      <= 1'b1;
            pend_word <= rd_word;
        end else if (cs_fall) begin
            pend <= 1'b0;
        end
    end

    assign load_word = pend ? pend_word : '0;

    sdb_miso_tx u_tx (
        .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_fall(sclk_fall), .load_word(load_word), .miso(miso)
    );
endmodule

// File: rtl/sdb_checker.sv
module sdb_checker
    import sdb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wrx,
    input logic              rdx,
    input logic              bus_oe,
    input logic              disp_dc,
    input logic [WORD_W-1:0] bus_out
);
    p_no_dual_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        !(!wrx && !rdx));

    p_release_in_read_r7: assert property (@(posedge clk) disable iff (rst)
        !rdx |-> !bus_oe);

    p_capture_undriven_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(rdx) |-> !bus_oe);

    p_write_driven_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(wrx) |-> bus_oe);

    p_write_data_held_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(wrx) |-> ($stable(bus_out) && $stable(disp_dc)));

    p_oe_drops_only_for_read_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_oe) |-> !rdx);
endmodule

bind spi_disp_bridge sdb_checker u_chk (
    .clk(clk), .rst(rst), .wrx(wrx), .rdx(rdx),
    .bus_oe(bus_oe), .disp_dc(disp_dc), .bus_out(bus_out)
);

// File: tb/spi_disp_bridge_test.sv
module spi_disp_bridge_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 6;
    localparam int GAP = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, dc = 1'b0;
    logic miso;
    logic [15:0] bus_in = 16'h0000;
    logic [15:0] bus_out;
    logic bus_oe, disp_dc, wrx, rdx;

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    bit finished = 0;

    logic [16:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_disp_bridge #(.STROBE_CYC(4)) uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .dc(dc),
        .miso(miso), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .disp_dc(disp_dc), .wrx(wrx), .rdx(rdx)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_wr(input logic d, input logic [15:0] w, input string tag);
        exp_q.push_back({d, w});
        tag_q.push_back(tag);
    endtask

    // monitor: compares every write strobe with the scoreboard, counts reads
    logic wrx_q = 1'b1, rdx_q = 1'b1;
    always @(negedge clk) begin
        if (!rst) begin
            if (wrx && !wrx_q) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R8 unexpected write actual=%h expected=none", {disp_dc, bus_out});
                end else begin
                    logic [16:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(t, {15'd0, disp_dc, bus_out}, {15'd0, e});
                    chk({t, " oe"}, {31'd0, bus_oe}, 32'd1);
                end
            end
            if (rdx && !rdx_q) rd_cnt++;
        end
        wrx_q <= wrx;
        rdx_q <= rdx;
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic d, input int nbits, input logic [15:0] w,
                        output logic [15:0] got);
        got = '0;
        dc = d;
        waitc(2);
        cs_n = 1'b0;
        waitc(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = w[i];
            waitc(HALF);
            got = {got[14:0], miso};
            sclk = 1'b1;
            waitc(HALF);
            sclk = 1'b0;
        end
        waitc(HALF);
        cs_n = 1'b1;
        waitc(GAP);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] g;
        int r0;
        waitc(4);
        rst = 1'b0;
        waitc(2);
        // R1 reset state
        chk("R1 wrx", {31'd0, wrx}, 32'd1);
        chk("R1 rdx", {31'd0, rdx}, 32'd1);
        chk("R1 oe", {31'd0, bus_oe}, 32'd1);
        chk("R1 bus", {16'd0, bus_out}, 32'd0);
        chk("R1 miso", {31'd0, miso}, 32'd0);

        // R4 command write, R6 opcode outside the table
        expect_wr(1'b0, 16'h002C, "R4 cmd 2C");
        xfer(1'b0, 8, 16'h002C, g);
        chk("R9 idle miso", {24'd0, g[7:0]}, 32'd0);
        // R5 data writes
        expect_wr(1'b1, 16'hA5C3, "R5 data A5C3");
        xfer(1'b1, 16, 16'hA5C3, g);
        expect_wr(1'b1, 16'h1234, "R5 data 1234");
        xfer(1'b1, 16, 16'h1234, g);
        // R2 extra clocks ignored: first 8 of 12 bits 0xB7 form the command
        expect_wr(1'b0, 16'h00B7, "R2 overlong cmd");
        xfer(1'b0, 12, 16'h0B71, g);
        // R3 short data frame right-justified
        expect_wr(1'b1, 16'h0ABC, "R3 short data");
        xfer(1'b1, 12, 16'h0ABC, g);
        // R3 empty window: no cycle
        r0 = rd_cnt;
        xfer(1'b1, 0, 16'h0000, g);
        chk("R3 empty no read", rd_cnt, r0);
        chk("R3 empty queue", exp_q.size(), 0);

        // R6/R7/R8/R9 read status, three words
        expect_wr(1'b0, 16'h0009, "R6 cmd 09");
        xfer(1'b0, 8, 16'h0009, g);
        r0 = rd_cnt;
        bus_in = 16'hC0DE;
        xfer(1'b1, 16, 16'hFFFF, g);
        chk("R9 dummy transfer miso", g, 16'h0000);
        chk("R7 first read", rd_cnt, r0 + 1);
        chk("R11 oe released", {31'd0, bus_oe}, 32'd0);
        bus_in = 16'h8E1F;
        xfer(1'b1, 16, 16'h0000, g);
        chk("R9 word1", g, 16'hC0DE);
        bus_in = 16'h3377;
        xfer(1'b1, 16, 16'hFFFF, g);
        chk("R9 word2", g, 16'h8E1F);
        xfer(1'b1, 16, 16'h1111, g);
        chk("R9 word3", g, 16'h3377);
        chk("R8 drain no read", rd_cnt, r0 + 3);
        chk("R8 drain no write", exp_q.size(), 0);
        expect_wr(1'b1, 16'h5555, "R8 write after drain");
        xfer(1'b1, 16, 16'h5555, g);
        chk("R9 no pending miso", g, 16'h0000);
        chk("R11 oe back", {31'd0, bus_oe}, 32'd1);

        // R6 one-word read 0x0A
        expect_wr(1'b0, 16'h000A, "R6 cmd 0A");
        xfer(1'b0, 8, 16'h000A, g);
        r0 = rd_cnt;
        bus_in = 16'h6A6A;
        xfer(1'b1, 16, 16'h2222, g);
        chk("R9 dummy 0A", g, 16'h0000);
        xfer(1'b1, 16, 16'h3333, g);
        chk("R9 word 0A", g, 16'h6A6A);
        chk("R7 one read", rd_cnt, r0 + 1);
        expect_wr(1'b1, 16'h0F0F, "R8 write after 0A");
        xfer(1'b1, 16, 16'h0F0F, g);

        // R10 abort: read 0x04 cut short by command 0x2A
        expect_wr(1'b0, 16'h0004, "R6 cmd 04");
        xfer(1'b0, 8, 16'h0004, g);
        r0 = rd_cnt;
        bus_in = 16'h9ABC;
        xfer(1'b1, 16, 16'h0000, g);
        expect_wr(1'b0, 16'h002A, "R10 cmd 2A");
        xfer(1'b0, 8, 16'h002A, g);
        chk("R9 word on cmd frame", {24'd0, g[7:0]}, 32'h9A);
        expect_wr(1'b1, 16'h7E81, "R10 data written");
        xfer(1'b1, 16, 16'h7E81, g);
        chk("R10 single read", rd_cnt, r0 + 1);
        chk("R10 queue drained", exp_q.size(), 0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule